// File: doc/BRIEF.md
# Memory-Type Cache Access Controller

This block sits between a processor load/store port and a small direct-mapped cache, and drives a word-wide backing-memory port. Each request carries a two-bit memory-type code. The code decides what a read or a write does on a hit or a miss:

- It may use the cache line alone.
- It may fill the line from memory.
- It may write memory directly.
- It may drop the resident line.

Write-back lines keep a dirty bit. A fill that lands on a dirty resident line first copies the old line out to memory, one word at a time.

The processor side uses a ready handshake. A request is taken only when `ready` is high. The block then stays busy until it raises `rsp_valid` for one cycle. For a read, that cycle also carries the read word. The cache holds 16 lines of 4 words of 32 bits by default. Addresses are word addresses, split from the top down into tag, line index and word offset.

Top module: `cpol_ctrl`

## Requirements
- R1: With type code 0 (write-back), a read hit returns the line word and makes no memory access. A read miss or a write miss reads the four words of the line from memory (offsets 0 to 3) before completing the request, and a read then returns the requested word.
- R2: With type code 0, a write hit updates only the cache line and marks it dirty, with no memory write. A write miss likewise leaves memory unchanged.
- R3: When a fill is needed and the resident line at that index is valid and dirty, its four words are first written to memory at their own addresses, offsets 0 to 3 in order, and only then is the new line read.
- R4: With type code 1 (uncacheable), a read is one memory word read and a write is one memory word write. The cache is left untouched even when a valid line with a matching tag is resident, so a read returns memory's value rather than the line's.
- R5: With type code 2 (write-through), a read miss fills the line and a read hit is served from the line. A write hit updates both the line and the memory word.
- R6: With type code 2, a write miss writes one memory word and allocates no line, so a later read of that address misses and fills.
- R7: With type code 3 (write-protect), reads behave as with code 2. A write hit writes one memory word and invalidates the line, discarding any dirty data without a writeback.
- R8: With type code 3, a write miss writes one memory word and leaves the cache unchanged.
- R9: `ready` is high only while idle. It is low in the cycle after a request is taken and throughout any fill, writeback or memory access. Each taken request yields exactly one single-cycle `rsp_valid` pulse.
- R10: After reset all lines are invalid and clean, `ready` is high, and neither `mem_req` nor `rsp_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when ready is high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_type | input | 2 | Memory type: 0 write-back, 1 uncacheable, 2 write-through, 3 write-protect |
| req_addr | input | ADDR_W | Word address {tag, index, offset} |
| req_wdata | input | DATA_W | Store data |
| ready | output | 1 | Controller idle and able to take a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Load data, valid with rsp_valid on loads |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory accepts the current word access |

## Verification
The hardest states to reach are those where a cache line and memory disagree. One is an uncacheable access that hits a dirty line. The other is a write-protect store to a line holding modified data. In both, the only visible sign of correct behaviour is that the stale or dirty data does not leak out.

The stimulus builds these states on purpose. A write-back store first dirties a line. An uncacheable read of the same address must then return memory's older value. A write-protect store then drops the dirty line, and a later read must refill it from memory. A conflicting write-back read forces a dirty eviction, and the bench checks the order of the written-back addresses against a memory model.

// File: rtl/cpol_pkg.sv
package cpol_pkg;
   typedef enum logic [1:0] {
      MT_WB = 2'd0,
      MT_UC = 2'd1,
      MT_WT = 2'd2,
      MT_WP = 2'd3
   } mtype_e;

   typedef enum logic [2:0] {
      ACT_LRD,    // serve read from line
      ACT_LWR,    // write line, mark dirty
      ACT_FILL,   // allocate line, then complete
      ACT_MEM,    // single memory word access, cache untouched
      ACT_THRU,   // write line and memory word
      ACT_DROP    // write memory word, then invalidate line
   } act_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_DECIDE,
      S_WBACK,
      S_FILL,
      S_APPLY,
      S_MEM,
      S_RESP
   } st_e;
endpackage

// File: rtl/cpol_policy.sv
module cpol_policy
   import cpol_pkg::*;
(
   input  mtype_e mtype,
   input  logic   is_write,
   input  logic   hit,
   output act_e   act
);
   always_comb begin
      act = ACT_MEM;
      unique case (mtype)
         MT_UC: act = ACT_MEM;
         MT_WB: act = hit ? (is_write ? ACT_LWR : ACT_LRD) : ACT_FILL;
         MT_WT: begin
            if (!is_write) act = hit ? ACT_LRD : ACT_FILL;
            else           act = hit ? ACT_THRU : ACT_MEM;
         end
         MT_WP: begin
            if (!is_write) act = hit ? ACT_LRD : ACT_FILL;
            else           act = hit ? ACT_DROP : ACT_MEM;
         end
         default: act = ACT_MEM;
      endcase
   end
endmodule

// File: rtl/cpol_tags.sv
module cpol_tags #(
   parameter int LINES = 16,
   parameter int TAG_W = 4,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             dirty_en,
   input  logic             inval_en,
   output logic             valid,
   output logic             dirty,
   output logic [TAG_W-1:0] tag
);
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   generate
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("cpol_tags: LINES must be a power of two, at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("cpol_tags: tag width must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
      end else begin
         if (inval_en) begin
            valid_q[idx] <= 1'b0;
            dirty_q[idx] <= 1'b0;
         end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
            tag_q[idx]   <= fill_tag;
         end else if (dirty_en) begin
            dirty_q[idx] <= 1'b1;
         end
      end
   end

   assign valid = valid_q[idx];
   assign dirty = dirty_q[idx];
   assign tag   = tag_q[idx];

   // R7
   inval_fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(inval_en && fill_en));

   // R2
   dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_en && !fill_en) |-> valid);
endmodule

// File: rtl/cpol_data.sv
module cpol_data #(
   parameter int DATA_W = 32,
   parameter int AW     = 6,
   localparam int DEPTH = 1 << AW
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] arr [DEPTH];

   always_ff @(posedge clk) begin
      if (we) arr[waddr] <= wdata;
   end

   assign rdata = arr[raddr];
endmodule

// File: rtl/cpol_ctrl.sv
module cpol_ctrl
   import cpol_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int LINES  = 16,
   parameter int WORDS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int OFF_W = $clog2(WORDS);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
   localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

   generate
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("cpol_ctrl: WORDS must be a power of two, at least 2");
      end
      if (TAG_W < 1) begin : g_bad_addr
         $error("cpol_ctrl: ADDR_W too small for LINES and WORDS");
      end
   endgenerate

   st_e               st;
   logic [OFF_W-1:0]  cnt;
   logic              r_we;
   mtype_e            r_type;
   logic [ADDR_W-1:0] r_addr;
   logic [DATA_W-1:0] r_wdata;
   logic [DATA_W-1:0] r_rdata;
   logic              r_inv;

   wire [TAG_W-1:0] r_tag = r_addr[ADDR_W-1 -: TAG_W];
   wire [IDX_W-1:0] r_idx = r_addr[OFF_W +: IDX_W];
   wire [OFF_W-1:0] r_off = r_addr[OFF_W-1:0];

   logic             lk_valid, lk_dirty;
   logic [TAG_W-1:0] lk_tag;
   logic             hit;
   act_e             act;

   logic              dwr_en;
   logic [OFF_W-1:0]  dwr_off;
   logic [DATA_W-1:0] dwr_data;
   logic [OFF_W-1:0]  drd_off;
   logic [DATA_W-1:0] drd_data;
   logic              tfill, tdirty, tinval;

   assign hit = lk_valid && (lk_tag == r_tag);

   cpol_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .idx(r_idx),
      .fill_en(tfill), .fill_tag(r_tag), .dirty_en(tdirty), .inval_en(tinval),
      .valid(lk_valid), .dirty(lk_dirty), .tag(lk_tag));

   cpol_data #(.DATA_W(DATA_W), .AW(IDX_W + OFF_W)) u_data (
      .clk(clk), .we(dwr_en), .waddr({r_idx, dwr_off}), .wdata(dwr_data),
      .raddr({r_idx, drd_off}), .rdata(drd_data));

   cpol_policy u_policy (
      .mtype(r_type), .is_write(r_we), .hit(hit), .act(act));

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = r_addr;
      mem_wdata = r_wdata;
      dwr_en    = 1'b0;
      dwr_off   = r_off;
      dwr_data  = r_wdata;
      drd_off   = r_off;
      tfill     = 1'b0;
      tdirty    = 1'b0;
      tinval    = 1'b0;
      unique case (st)
         S_DECIDE: begin
            if (act == ACT_LWR) begin
               dwr_en = 1'b1;
               tdirty = 1'b1;
            end else if (act == ACT_THRU) begin
               dwr_en = 1'b1;
            end
         end
         S_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {lk_tag, r_idx, cnt};
            drd_off   = cnt;
            mem_wdata = drd_data;
         end
         S_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {r_tag, r_idx, cnt};
            dwr_en   = mem_ack;
            dwr_off  = cnt;
            dwr_data = mem_rdata;
            tfill    = mem_ack && (cnt == LAST);
         end
         S_APPLY: begin
            if (r_we) begin
               dwr_en = 1'b1;
               tdirty = 1'b1;
            end
         end
         S_MEM: begin
            mem_req = 1'b1;
            mem_we  = r_we;
            tinval  = mem_ack && r_inv;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cnt     <= '0;
         r_we    <= 1'b0;
         r_type  <= MT_WB;
         r_addr  <= '0;
         r_wdata <= '0;
         r_rdata <= '0;
         r_inv   <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: if (req_valid) begin
               r_we    <= req_write;
               r_type  <= mtype_e'(req_type);
               r_addr  <= req_addr;
               r_wdata <= req_wdata;
               r_inv   <= 1'b0;
               st      <= S_DECIDE;
            end
            S_DECIDE: begin
               unique case (act)
                  ACT_LRD: begin r_rdata <= drd_data; st <= S_RESP; end
                  ACT_LWR: st <= S_RESP;
                  ACT_THRU: st <= S_MEM;
                  ACT_DROP: begin r_inv <= 1'b1; st <= S_MEM; end
                  ACT_FILL: begin
                     cnt <= '0;
                     st  <= (lk_valid && lk_dirty) ? S_WBACK : S_FILL;
                  end
                  default: st <= S_MEM;
               endcase
            end
            S_WBACK: if (mem_ack) begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) st <= S_FILL;
            end
            S_FILL: if (mem_ack) begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) st <= S_APPLY;
            end
            S_APPLY: begin
               if (!r_we) r_rdata <= drd_data;
               st <= S_RESP;
            end
            S_MEM: if (mem_ack) begin
               if (!r_we) r_rdata <= mem_rdata;
               st <= S_RESP;
            end
            S_RESP: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign ready     = (st == S_IDLE);
   assign rsp_valid = (st == S_RESP);
   assign rsp_rdata = r_rdata;

   // R9
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ready);

   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && ready));

   // R2
   wb_memwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && r_type == MT_WB) |-> (st == S_WBACK));

   // R4
   uc_nocache_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_type == MT_UC && st != S_IDLE) |-> (!dwr_en && !tfill && !tdirty && !tinval));

   // R6
   wr_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_we && (r_type == MT_WT || r_type == MT_WP) && st != S_IDLE) |-> !tfill);

   // R7
   wp_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_MEM && mem_ack && r_inv) |=> !lk_valid);

   // R3
   wback_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WBACK && mem_ack && cnt == LAST) |=> (st == S_FILL && cnt == '0));
endmodule

// File: tb/tb_cpol_ctrl.sv
module tb_cpol_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_type = 2'd0;
   logic [9:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        ready, rsp_valid, mem_req, mem_we, mem_ack;
   logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
   logic [9:0]  mem_addr;

   always #4 clk = ~clk;

   cpol_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
      .ready(ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

   // backing memory model
   logic [31:0] mem [1024];
   logic [9:0]  wlog [64];
   int          nrd = 0, nwr = 0;
   initial for (int i = 0; i < 1024; i++) mem[i] = 32'h5000_0000 | i;
   assign mem_ack   = mem_req;
   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) begin
      if (mem_req && mem_ack) begin
         if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (nwr < 64) wlog[nwr] <= mem_addr;
            nwr <= nwr + 1;
         end else begin
            nrd <= nrd + 1;
         end
      end
   end

   int errors = 0, checks = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic        we;
      logic [1:0]  mt;
      logic [9:0]  addr;
      logic [31:0] wd;
      logic [31:0] exp;
      logic [3:0]  erd;
      logic [3:0]  ewr;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd0, 10'h005, 32'h0,          32'h5000_0005, 4'd4, 4'd0, 4'd1}, // R1 miss fill, R10 empty
      '{1'b0, 2'd0, 10'h006, 32'h0,          32'h5000_0006, 4'd0, 4'd0, 4'd1}, // R1 hit
      '{1'b1, 2'd0, 10'h006, 32'hDEAD_0006,  32'h0,         4'd0, 4'd0, 4'd2}, // R2 write hit
      '{1'b0, 2'd0, 10'h006, 32'h0,          32'hDEAD_0006, 4'd0, 4'd0, 4'd2}, // R2 line updated
      '{1'b0, 2'd1, 10'h006, 32'h0,          32'h5000_0006, 4'd1, 4'd0, 4'd4}, // R4 stale hit bypass
      '{1'b1, 2'd1, 10'h007, 32'h1111_0007,  32'h0,         4'd0, 4'd1, 4'd4}, // R4 UC write
      '{1'b0, 2'd0, 10'h007, 32'h0,          32'h5000_0007, 4'd0, 4'd0, 4'd4}, // R4 line untouched
      '{1'b0, 2'd0, 10'h046, 32'h0,          32'h5000_0046, 4'd4, 4'd4, 4'd3}, // R3 dirty conflict
      '{1'b0, 2'd1, 10'h006, 32'h0,          32'hDEAD_0006, 4'd1, 4'd0, 4'd3}, // R3 writeback landed
      '{1'b0, 2'd2, 10'h010, 32'h0,          32'h5000_0010, 4'd4, 4'd0, 4'd5}, // R5 WT read miss
      '{1'b1, 2'd2, 10'h011, 32'h2222_0011,  32'h0,         4'd0, 4'd1, 4'd5}, // R5 WT write hit
      '{1'b0, 2'd1, 10'h011, 32'h0,          32'h2222_0011, 4'd1, 4'd0, 4'd5}, // R5 memory updated
      '{1'b0, 2'd2, 10'h011, 32'h0,          32'h2222_0011, 4'd0, 4'd0, 4'd5}, // R5 line updated
      '{1'b1, 2'd2, 10'h020, 32'h3333_0020,  32'h0,         4'd0, 4'd1, 4'd6}, // R6 WT write miss
      '{1'b0, 2'd2, 10'h020, 32'h0,          32'h3333_0020, 4'd4, 4'd0, 4'd6}, // R6 no allocation
      '{1'b0, 2'd3, 10'h030, 32'h0,          32'h5000_0030, 4'd4, 4'd0, 4'd7}, // R7 WP read fill
      '{1'b1, 2'd0, 10'h031, 32'h4444_0031,  32'h0,         4'd0, 4'd0, 4'd7}, // R7 dirty the line
      '{1'b1, 2'd3, 10'h030, 32'h5555_0030,  32'h0,         4'd0, 4'd1, 4'd7}, // R7 WP write hit
      '{1'b0, 2'd3, 10'h031, 32'h0,          32'h5000_0031, 4'd4, 4'd0, 4'd7}, // R7 dirty dropped
      '{1'b1, 2'd3, 10'h0F3, 32'h6666_00F3,  32'h0,         4'd0, 4'd1, 4'd8}, // R8 WP write miss
      '{1'b0, 2'd3, 10'h031, 32'h0,          32'h5000_0031, 4'd0, 4'd0, 4'd8}, // R8 resident kept
      '{1'b0, 2'd1, 10'h0F3, 32'h0,          32'h6666_00F3, 4'd1, 4'd0, 4'd8}, // R8 memory written
      '{1'b1, 2'd0, 10'h0A8, 32'h7777_00A8,  32'h0,         4'd4, 4'd0, 4'd1}, // R1 write miss fill
      '{1'b0, 2'd1, 10'h0A8, 32'h0,          32'h5000_00A8, 4'd1, 4'd0, 4'd2}, // R2 memory untouched
      '{1'b0, 2'd0, 10'h0A8, 32'h0,          32'h7777_00A8, 4'd0, 4'd0, 4'd2}  // R2 line holds store
   };

   logic [31:0] got_data;
   int          got_rd, got_wr, wr_base;

   task automatic run(input logic we, input logic [1:0] mt, input logic [9:0] a,
                      input logic [31:0] wd);
      int rd0, wr0, t;
      @(negedge clk);
      rd0 = nrd; wr0 = nwr; wr_base = nwr;
      req_valid = 1'b1; req_write = we; req_type = mt; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(ready == 1'b0, "R9", "ready after accept", {31'b0, ready}, 32'd0);
      t = 0;
      while (!rsp_valid && t < 200) begin
         @(negedge clk);
         t++;
      end
      if (!rsp_valid) chk(1'b0, "R9", "watchdog no response", 32'd0, 32'd1);
      got_data = rsp_rdata;
      got_rd = nrd - rd0;
      got_wr = nwr - wr0;
      @(negedge clk);
      chk(!rsp_valid && ready, "R9", "single pulse then idle",
          {30'b0, rsp_valid, ready}, 32'd1);
   endtask

   initial begin
      #1_000_000;
      chk(1'b0, "R9", "global watchdog", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(ready == 1'b1 && mem_req == 1'b0 && rsp_valid == 1'b0, "R10", "in reset",
          {29'b0, ready, mem_req, rsp_valid}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready == 1'b1 && mem_req == 1'b0 && rsp_valid == 1'b0, "R10", "after reset",
          {29'b0, ready, mem_req, rsp_valid}, 32'h4);

      for (int v = 0; v < NV; v++) begin
         string rs;
         rs = $sformatf("R%0d", VEC[v].rq);
         run(VEC[v].we, VEC[v].mt, VEC[v].addr, VEC[v].wd);
         if (!VEC[v].we)
            chk(got_data == VEC[v].exp, rs, $sformatf("vec %0d read data", v),
                got_data, VEC[v].exp);
         chk(got_rd == int'(VEC[v].erd), rs, $sformatf("vec %0d memory reads", v),
             got_rd, {28'b0, VEC[v].erd});
         chk(got_wr == int'(VEC[v].ewr), rs, $sformatf("vec %0d memory writes", v),
             got_wr, {28'b0, VEC[v].ewr});
         if (v == 7) begin
            // R3 writeback order: old line words 0x004..0x007
            for (int k = 0; k < 4; k++)
               chk(wlog[wr_base + k] == 10'h004 + 10'(k), "R3",
                   $sformatf("writeback address %0d", k),
                   {22'b0, wlog[wr_base + k]}, 32'h004 + k);
            chk(mem[10'h006] == 32'hDEAD_0006, "R3", "written-back dirty word",
                mem[10'h006], 32'hDEAD_0006);
         end
      end

      // R10 reset clears all lines: line 0x046 was resident before reset
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      run(1'b0, 2'd0, 10'h046, 32'h0);
      chk(got_rd == 4, "R10", "refill after reset", got_rd, 32'd4);
      chk(got_data == 32'h5000_0046, "R10", "data after reset", got_data, 32'h5000_0046);

      // R9 request held high during a long fill is taken once
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_type = 2'd0; req_addr = 10'h100;
      begin
         int pulses = 0;
         for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (c == 0) req_valid = 1'b0;
            if (rsp_valid) pulses++;
         end
         chk(pulses == 1, "R9", "one response per request", pulses, 32'd1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule